// File: doc/BRIEF.md
# Feeder Auto-Reclose Sequence Controller

This block sequences the trip and close commands of a medium-voltage feeder interrupter. Every cycle it receives a current magnitude and a programmed maximum load current, and from these it decides whether a fault is present. A fault that persists for the trip delay produces a one-cycle trip pulse. After the breaker reports that it is open, the controller waits a dead time and then issues a one-cycle close pulse to attempt a reclose. Each successive attempt (a "shot") uses a longer dead time. If the breaker stays closed with current below pickup for a reset window, the shot count returns to zero.

A fault above a high-current limit trips fast and goes straight to lockout, with no reclose. A fault that trips again after the last shot also ends in lockout. The final shot uses a stretched dead time and raises an alarm. The alarm and the lockout both hold until an operator pulses manual reset. After the breaker is re-energized from rest, the pickup level is raised for a programmable cold-load window. All delays count a 1 ms strobe and not the clock.

Top module: `feeder_reclose_ctrl`

## Requirements
- R1: A fault is recognised only when cur_mag × PU_DEN > load_set × PU_NUM (default 6/5, i.e. strictly above 1.2 × load). A current at or below that level never trips.
- R2: With a fault present and below the high limit, trip_cmd pulses after TRIP_MS strobes. The pulse appears TRIP_MS+2 clock cycles after the current change when the strobe is high every cycle.
- R3: When cur_mag > HIGH_LIMIT, the trip delay is FAST_MS strobes. The trip goes straight to lockout with no close, whatever the shot count.
- R4: When the breaker opens after a non-final trip, close_cmd pulses after the dead time for the current shot: DEAD1_MS for shot 0, DEAD2_MS for shot 1, DEAD3_MS for later shots. shot_count then increments on the same edge.
- R5: The last shot (index SHOTS-1) uses FINAL_MS as its dead time. alarm rises on the clock edge after the breaker opens for that shot.
- R6: A trip that occurs when shot_count equals SHOTS enters lockout. While locked out, close_cmd is never asserted.
- R7: locked_out and alarm hold until man_reset. man_reset in lockout returns the controller to idle with shot_count 0 and alarm low on the next edge.
- R8: After a reclose, once RECLAIM_MS strobes have passed with the breaker closed and no fault, shot_count returns to 0.
- R9: A closed transition of brk_open while the controller is idle or locked out starts a cold-load window of cold_win_ms strobes, shown on cold_pickup. During the window the pickup is cur × CLP_DEN > load × CLP_NUM (default 2 × load).
- R10: trip_cmd and close_cmd are single-cycle pulses and are never high in the same cycle.
- R11: Timers advance only on cycles with tick_ms high. While the strobe is held low, a standing fault does not trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | Timebase strobe, one cycle per millisecond |
| cur_mag | input | CUR_W | Measured current magnitude, amperes |
| load_set | input | CUR_W | Programmed maximum load current, amperes |
| brk_open | input | 1 | Breaker status, 1 = open |
| man_reset | input | 1 | Operator reset of lockout and alarm |
| cold_win_ms | input | TMR_W | Cold-load window length in strobes |
| trip_cmd | output | 1 | One-cycle trip command |
| close_cmd | output | 1 | One-cycle close command |
| locked_out | output | 1 | Lockout state |
| alarm | output | 1 | Persistent-fault / lockout alarm |
| shot_count | output | SHOT_W | Closes issued in the current sequence |
| cold_pickup | output | 1 | Cold-load window active |

## Verification
With the strobe high every cycle, the results fall at these cycle offsets:
- A trip appears the stated delay plus two cycles after the current changes: one cycle for the registered pickup flag and one for entering the pickup state.
- A close appears the dead time plus one cycle after the breaker-open status is applied.
- A re-trip after a reclose comes the trip delay plus two cycles after the close.
- The cold-load window is visible from the cycle after the breaker closes through the window length.

The bench driver computes each expected pulse's cycle from these offsets and queues it. A monitor stamps every observed pulse with the cycle count, compares it against the head of the queue, and models the breaker by reacting on the same sampling edge, so the derived offsets stay exact. Level outputs are checked on the cycle before and the cycle after each predicted change.

// File: rtl/frc_pkg.sv
`timescale 1ns/1ps
package frc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICKUP,
    ST_OPENING,
    ST_DEAD,
    ST_CLOSING,
    ST_RECLAIM,
    ST_LOCKOUT
  } frc_state_t;

  // Dead time for a shot index: the last shot takes the stretched value.
  function automatic int frc_dead_ms(input int idx, input int shots,
                                     input int d1, input int d2,
                                     input int d3, input int dfin);
    if (idx >= shots - 1) return dfin;
    else if (idx == 0)    return d1;
    else if (idx == 1)    return d2;
    else                  return d3;
  endfunction

endpackage

// File: rtl/frc_timer.sv
`timescale 1ns/1ps
module frc_timer #(
  parameter int TMR_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic [TMR_W-1:0] limit,
  output logic             expire
);

  logic [TMR_W-1:0] cnt;
  logic [TMR_W-1:0] lim_m1;

  always_comb begin
    lim_m1 = (limit == '0) ? '0 : limit - TMR_W'(1);
    expire = tick && (cnt >= lim_m1);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (tick && (cnt != {TMR_W{1'b1}})) begin
      cnt <= cnt + TMR_W'(1);
    end
  end

endmodule

// File: rtl/frc_pickup.sv
`timescale 1ns/1ps
module frc_pickup #(
  parameter int CUR_W      = 16,
  parameter int TMR_W      = 20,
  parameter int PU_NUM     = 6,
  parameter int PU_DEN     = 5,
  parameter int CLP_NUM    = 2,
  parameter int CLP_DEN    = 1,
  parameter int HIGH_LIMIT = 10000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CUR_W-1:0] cur,
  input  logic [CUR_W-1:0] load,
  input  logic             brk_open,
  input  logic             quiet,
  input  logic [TMR_W-1:0] cold_win,
  output logic             flt_q,
  output logic             hi_q,
  output logic             cold_q
);

  localparam int PW = CUR_W + 8;

  logic [PW-1:0] cur_pu, lim_pu, cur_cl, lim_cl;
  logic          over_pu, over_cl, over_hi;
  logic          brk_q, energize, cold_exp;

  always_comb begin
    cur_pu  = PW'(cur)  * PW'(PU_DEN);
    lim_pu  = PW'(load) * PW'(PU_NUM);
    cur_cl  = PW'(cur)  * PW'(CLP_DEN);
    lim_cl  = PW'(load) * PW'(CLP_NUM);
    over_pu = cur_pu > lim_pu;
    over_cl = cur_cl > lim_cl;
    over_hi = PW'(cur) > PW'(HIGH_LIMIT);
    energize = brk_q && !brk_open && quiet;
  end

  frc_timer #(.TMR_W(TMR_W)) u_cold_tmr (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .restart (energize),
    .limit   (cold_win),
    .expire  (cold_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_q  <= 1'b0;
      cold_q <= 1'b0;
      flt_q  <= 1'b0;
      hi_q   <= 1'b0;
    end else begin
      brk_q <= brk_open;
      if (energize)
        cold_q <= 1'b1;
      else if (cold_q && (brk_open || cold_exp))
        cold_q <= 1'b0;
      flt_q <= (cold_q ? over_cl : over_pu) || over_hi;
      hi_q  <= over_hi;
    end
  end

endmodule

// File: rtl/frc_seq.sv
`timescale 1ns/1ps
module frc_seq
  import frc_pkg::*;
#(
  parameter int SHOTS      = 4,
  parameter int SHOT_W     = 3,
  parameter int TMR_W      = 20,
  parameter int TRIP_MS    = 300,
  parameter int FAST_MS    = 100,
  parameter int DEAD1_MS   = 1000,
  parameter int DEAD2_MS   = 30000,
  parameter int DEAD3_MS   = 120000,
  parameter int FINAL_MS   = 300000,
  parameter int RECLAIM_MS = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              flt,
  input  logic              hi,
  input  logic              brk_open,
  input  logic              man_reset,
  output logic              trip_cmd,
  output logic              close_cmd,
  output logic              locked_out,
  output logic              alarm,
  output logic [SHOT_W-1:0] shot_cnt,
  output logic              quiet
);

  frc_state_t        state, state_n;
  logic              trip_n, close_n, alarm_n;
  logic [SHOT_W-1:0] shot_n;
  logic [TMR_W-1:0]  lim;
  logic              tmr_exp;
  logic              restart;

  always_comb begin
    case (state)
      ST_PICKUP:  lim = hi ? TMR_W'(FAST_MS) : TMR_W'(TRIP_MS);
      ST_DEAD:    lim = TMR_W'(frc_dead_ms(int'(shot_cnt), SHOTS, DEAD1_MS,
                                           DEAD2_MS, DEAD3_MS, FINAL_MS));
      ST_RECLAIM: lim = TMR_W'(RECLAIM_MS);
      default:    lim = TMR_W'(TRIP_MS);
    endcase
  end

  frc_timer #(.TMR_W(TMR_W)) u_seq_tmr (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .restart (restart),
    .limit   (lim),
    .expire  (tmr_exp)
  );

  always_comb begin
    state_n = state;
    trip_n  = 1'b0;
    close_n = 1'b0;
    shot_n  = shot_cnt;
    alarm_n = alarm && !man_reset;
    case (state)
      ST_IDLE: begin
        if (flt && !brk_open) state_n = ST_PICKUP;
      end
      ST_PICKUP: begin
        if (!flt) begin
          state_n = (shot_cnt == '0) ? ST_IDLE : ST_RECLAIM;
        end else if (tmr_exp) begin
          trip_n = 1'b1;
          if (hi || (shot_cnt == SHOT_W'(SHOTS))) begin
            state_n = ST_LOCKOUT;
            alarm_n = 1'b1;
          end else begin
            state_n = ST_OPENING;
          end
        end
      end
      ST_OPENING: begin
        if (brk_open) begin
          state_n = ST_DEAD;
          if (shot_cnt == SHOT_W'(SHOTS - 1)) alarm_n = 1'b1;
        end
      end
      ST_DEAD: begin
        if (tmr_exp) begin
          close_n = 1'b1;
          shot_n  = shot_cnt + SHOT_W'(1);
          state_n = ST_CLOSING;
        end
      end
      ST_CLOSING: begin
        if (!brk_open) state_n = ST_RECLAIM;
      end
      ST_RECLAIM: begin
        if (flt) begin
          state_n = ST_PICKUP;
        end else if (tmr_exp) begin
          state_n = ST_IDLE;
          shot_n  = '0;
        end
      end
      ST_LOCKOUT: begin
        if (man_reset) begin
          state_n = ST_IDLE;
          shot_n  = '0;
          alarm_n = 1'b0;
        end else begin
          alarm_n = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
    restart = (state_n != state);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      trip_cmd  <= 1'b0;
      close_cmd <= 1'b0;
      shot_cnt  <= '0;
      alarm     <= 1'b0;
    end else begin
      state     <= state_n;
      trip_cmd  <= trip_n;
      close_cmd <= close_n;
      shot_cnt  <= shot_n;
      alarm     <= alarm_n;
    end
  end

  assign locked_out = (state == ST_LOCKOUT);
  assign quiet      = (state == ST_IDLE) || (state == ST_LOCKOUT);

endmodule

// File: rtl/feeder_reclose_ctrl.sv
`timescale 1ns/1ps
module feeder_reclose_ctrl #(
  parameter int CUR_W      = 16,
  parameter int TMR_W      = 20,
  parameter int SHOTS      = 4,
  parameter int TRIP_MS    = 300,
  parameter int FAST_MS    = 100,
  parameter int DEAD1_MS   = 1000,
  parameter int DEAD2_MS   = 30000,
  parameter int DEAD3_MS   = 120000,
  parameter int FINAL_MS   = 300000,
  parameter int RECLAIM_MS = 10000,
  parameter int HIGH_LIMIT = 10000,
  parameter int PU_NUM     = 6,
  parameter int PU_DEN     = 5,
  parameter int CLP_NUM    = 2,
  parameter int CLP_DEN    = 1,
  localparam int SHOT_W    = $clog2(SHOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_ms,
  input  logic [CUR_W-1:0]  cur_mag,
  input  logic [CUR_W-1:0]  load_set,
  input  logic              brk_open,
  input  logic              man_reset,
  input  logic [TMR_W-1:0]  cold_win_ms,
  output logic              trip_cmd,
  output logic              close_cmd,
  output logic              locked_out,
  output logic              alarm,
  output logic [SHOT_W-1:0] shot_count,
  output logic              cold_pickup
);

  logic flt, hi, quiet;

  frc_pickup #(
    .CUR_W      (CUR_W),
    .TMR_W      (TMR_W),
    .PU_NUM     (PU_NUM),
    .PU_DEN     (PU_DEN),
    .CLP_NUM    (CLP_NUM),
    .CLP_DEN    (CLP_DEN),
    .HIGH_LIMIT (HIGH_LIMIT)
  ) u_pickup (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_ms),
    .cur      (cur_mag),
    .load     (load_set),
    .brk_open (brk_open),
    .quiet    (quiet),
    .cold_win (cold_win_ms),
    .flt_q    (flt),
    .hi_q     (hi),
    .cold_q   (cold_pickup)
  );

  frc_seq #(
    .SHOTS      (SHOTS),
    .SHOT_W     (SHOT_W),
    .TMR_W      (TMR_W),
    .TRIP_MS    (TRIP_MS),
    .FAST_MS    (FAST_MS),
    .DEAD1_MS   (DEAD1_MS),
    .DEAD2_MS   (DEAD2_MS),
    .DEAD3_MS   (DEAD3_MS),
    .FINAL_MS   (FINAL_MS),
    .RECLAIM_MS (RECLAIM_MS)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick_ms),
    .flt        (flt),
    .hi         (hi),
    .brk_open   (brk_open),
    .man_reset  (man_reset),
    .trip_cmd   (trip_cmd),
    .close_cmd  (close_cmd),
    .locked_out (locked_out),
    .alarm      (alarm),
    .shot_cnt   (shot_count),
    .quiet      (quiet)
  );

endmodule

// File: rtl/frc_checker.sv
`timescale 1ns/1ps
module frc_checker #(
  parameter int SHOTS  = 4,
  parameter int SHOT_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              trip_cmd,
  input logic              close_cmd,
  input logic              locked_out,
  input logic              alarm,
  input logic              man_reset,
  input logic [SHOT_W-1:0] shot_count
);

  AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(trip_cmd && close_cmd)); // R10
  AST_TRIP_PULSE: assert property (@(posedge clk) disable iff (rst) trip_cmd |=> !trip_cmd); // R10
  AST_CLOSE_PULSE: assert property (@(posedge clk) disable iff (rst) close_cmd |=> !close_cmd); // R10
  AST_NO_CLOSE_LOCKED: assert property (@(posedge clk) disable iff (rst) locked_out |-> !close_cmd); // R6
  AST_SHOT_BOUND: assert property (@(posedge clk) disable iff (rst) shot_count <= SHOT_W'(SHOTS)); // R6
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst) (locked_out && !man_reset) |=> locked_out); // R7
  AST_ALARM_HOLD: assert property (@(posedge clk) disable iff (rst) (alarm && !man_reset) |=> alarm); // R7
  AST_RESET_EXIT: assert property (@(posedge clk) disable iff (rst) (locked_out && man_reset) |=> (!locked_out && !alarm && shot_count == '0)); // R7
  AST_ALARM_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(alarm) |-> (locked_out || shot_count == SHOT_W'(SHOTS - 1))); // R5

endmodule

bind feeder_reclose_ctrl frc_checker #(.SHOTS(SHOTS), .SHOT_W(SHOT_W)) u_frc_checker (
  .clk        (clk),
  .rst        (rst),
  .trip_cmd   (trip_cmd),
  .close_cmd  (close_cmd),
  .locked_out (locked_out),
  .alarm      (alarm),
  .man_reset  (man_reset),
  .shot_count (shot_count)
);

// File: tb/feeder_reclose_ctrl_test.sv
`timescale 1ns/1ps
module feeder_reclose_ctrl_test;

  localparam int CUR_W = 16;
  localparam int TMR_W = 20;
  localparam int SHOTS = 4;
  localparam int LT = 6, LF = 3, D1 = 10, D2 = 14, D3 = 18, DF = 25, RC = 12;
  localparam int CW = 20;
  localparam int SW = $clog2(SHOTS + 1);

  logic clk = 1'b0, rst = 1'b1, tick_ms = 1'b1, brk_open = 1'b0, man_reset = 1'b0;
  logic [CUR_W-1:0] cur_mag = '0, load_set = 16'd500;
  logic [TMR_W-1:0] cold_win_ms = TMR_W'(CW);
  logic trip_cmd, close_cmd, locked_out, alarm, cold_pickup;
  logic [SW-1:0] shot_count;

  int cyc = 0, checks = 0, fails = 0, trips_seen = 0;
  bit auto_brk = 1'b1, clr_on_trip = 1'b0, done = 1'b0;

  typedef struct { bit is_close; int at; string req; } ev_t;
  ev_t expq[$];

  feeder_reclose_ctrl #(
    .CUR_W(CUR_W), .TMR_W(TMR_W), .SHOTS(SHOTS), .TRIP_MS(LT), .FAST_MS(LF),
    .DEAD1_MS(D1), .DEAD2_MS(D2), .DEAD3_MS(D3), .FINAL_MS(DF), .RECLAIM_MS(RC),
    .HIGH_LIMIT(10000), .PU_NUM(6), .PU_DEN(5), .CLP_NUM(2), .CLP_DEN(1)
  ) uut (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .cur_mag(cur_mag), .load_set(load_set),
    .brk_open(brk_open), .man_reset(man_reset), .cold_win_ms(cold_win_ms),
    .trip_cmd(trip_cmd), .close_cmd(close_cmd), .locked_out(locked_out),
    .alarm(alarm), .shot_count(shot_count), .cold_pickup(cold_pickup)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic push_ev(input bit is_close, input int at, input string req);
    ev_t e;
    e.is_close = is_close; e.at = at; e.req = req;
    expq.push_back(e);
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic take_event(input bit is_close);
    ev_t e;
    if (expq.size() == 0) begin
      chk(1'b0, is_close ? "R6" : "R1", is_close ? "unexpected close" : "unexpected trip",
          cyc, -1);
    end else begin
      e = expq.pop_front();
      chk(e.is_close == is_close, e.req, "pulse kind (1=close)", int'(is_close), int'(e.is_close));
      chk(e.at == cyc, e.req, is_close ? "close cycle" : "trip cycle", cyc, e.at);
    end
    if (!is_close) trips_seen++;
    if (auto_brk) brk_open = !is_close;
    if (!is_close && clr_on_trip) cur_mag = '0;
  endtask

  // Monitor: scoreboard pops and compares each pulse, models the breaker.
  always @(negedge clk) begin
    if (!rst && (trip_cmd || close_cmd)) begin
      chk(!(trip_cmd && close_cmd), "R10", "trip and close together",
          int'(trip_cmd && close_cmd), 0);
      if (trip_cmd)  take_event(1'b0);
      if (close_cmd) take_event(1'b1);
    end
  end

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog expired: actual %0d expected %0d", cyc, 0);
      report();
      $finish;
    end
  end

  task automatic pulse_reset;
    man_reset = 1'b1;
    @(negedge clk);
    man_reset = 1'b0;
  endtask

  initial begin
    int c0, c1, t, k, m;
    int t1, k1, t2, k2, t3, k3, t4, k4, t5;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!trip_cmd && !close_cmd, "R10", "commands after reset", int'(trip_cmd || close_cmd), 0);
    chk(!locked_out && !alarm, "R7", "lockout/alarm after reset", int'(locked_out || alarm), 0);
    chk(shot_count == 0 && !cold_pickup, "R8", "shots/cold after reset", int'(shot_count), 0);

    // R1: exactly 1.2 x load must not trip
    cur_mag = 16'd600;
    repeat (30) @(negedge clk);
    chk(trips_seen == 0, "R1", "trips at exact pickup", trips_seen, 0);
    cur_mag = '0;
    repeat (3) @(negedge clk);

    // R11: strobe low freezes timers; then R4 first dead time and R8 reclaim
    tick_ms = 1'b0; clr_on_trip = 1'b1;
    c0 = cyc; cur_mag = 16'd700;
    wait_to(c0 + 30);
    chk(trips_seen == 0, "R11", "trips without strobe", trips_seen, 0);
    c1 = cyc; t = c1 + LT; k = t + 1 + D1;
    push_ev(1'b0, t, "R11"); push_ev(1'b1, k, "R4");
    tick_ms = 1'b1;
    wait_to(k);
    chk(shot_count == 1, "R4", "shots after first close", int'(shot_count), 1);
    wait_to(k + 2);
    chk(!cold_pickup, "R9", "cold window after reclose", int'(cold_pickup), 0);
    wait_to(k + RC);
    chk(shot_count == 1, "R8", "shots before reclaim ends", int'(shot_count), 1);
    wait_to(k + RC + 1);
    chk(shot_count == 0, "R8", "shots after reclaim", int'(shot_count), 0);
    clr_on_trip = 1'b0;
    repeat (3) @(negedge clk);

    // Persistent fault: all shots, stretched final dead time, lockout
    c0 = cyc; cur_mag = 16'd700;
    t1 = c0 + LT + 2; k1 = t1 + 1 + D1;
    t2 = k1 + 2 + LT; k2 = t2 + 1 + D2;
    t3 = k2 + 2 + LT; k3 = t3 + 1 + D3;
    t4 = k3 + 2 + LT; k4 = t4 + 1 + DF;
    t5 = k4 + 2 + LT;
    push_ev(1'b0, t1, "R2"); push_ev(1'b1, k1, "R4");
    push_ev(1'b0, t2, "R2"); push_ev(1'b1, k2, "R4");
    push_ev(1'b0, t3, "R2"); push_ev(1'b1, k3, "R4");
    push_ev(1'b0, t4, "R2"); push_ev(1'b1, k4, "R5");
    push_ev(1'b0, t5, "R6");
    wait_to(t4);
    chk(!alarm, "R5", "alarm before final dead time", int'(alarm), 0);
    wait_to(t4 + 1);
    chk(alarm, "R5", "alarm at final dead time", int'(alarm), 1);
    wait_to(k4);
    chk(shot_count == SW'(SHOTS), "R4", "shots at last close", int'(shot_count), SHOTS);
    wait_to(t5);
    chk(locked_out && alarm, "R6", "lockout after shots used", int'(locked_out), 1);
    wait_to(t5 + 40);
    chk(locked_out && alarm, "R7", "lockout held without reset", int'(locked_out && alarm), 1);
    cur_mag = '0;
    m = cyc;
    pulse_reset();
    chk(!locked_out && !alarm && shot_count == 0 && cyc == m + 1, "R7",
        "state after manual reset", int'(locked_out || alarm), 0);
    repeat (3) @(negedge clk);

    // R9: re-energize from rest raises pickup for the window
    c0 = cyc; brk_open = 1'b0;
    @(negedge clk);
    chk(cold_pickup, "R9", "cold window start", int'(cold_pickup), 1);
    cur_mag = 16'd700; clr_on_trip = 1'b1;
    t = c0 + CW + LT + 3; k = t + 1 + D1;
    push_ev(1'b0, t, "R9"); push_ev(1'b1, k, "R4");
    wait_to(c0 + CW);
    chk(cold_pickup, "R9", "cold window last cycle", int'(cold_pickup), 1);
    wait_to(c0 + CW + 1);
    chk(!cold_pickup, "R9", "cold window ended", int'(cold_pickup), 0);
    wait_to(k + RC + 3);
    chk(shot_count == 0, "R8", "shots after cold reclose", int'(shot_count), 0);
    clr_on_trip = 1'b0;

    // R3: high current trips fast and locks out with no reclose
    c0 = cyc; cur_mag = 16'd12000;
    t = c0 + LF + 2;
    push_ev(1'b0, t, "R3");
    wait_to(t);
    chk(locked_out && alarm && shot_count == 0, "R3", "lockout on high current",
        int'(locked_out), 1);
    wait_to(t + 40);
    chk(locked_out, "R3", "no reclose after high current", int'(locked_out), 1);
    cur_mag = '0;
    pulse_reset();
    chk(!locked_out && !alarm, "R7", "reset after high-current lockout", int'(locked_out), 0);

    repeat (5) @(negedge clk);
    chk(expq.size() == 0, "R2", "pulses still expected", expq.size(), 0);
    done = 1'b1;
    report();
    $finish;
  end

endmodule